// File: doc/BRIEF.md
# Scan-Sensor Command Decoder with Zone Register File

This block sits behind the serial byte receiver of a linear image sensor controller. Every received byte is classified in one of three ways. It can be a one-byte action command, which raises one or more single-cycle strobes towards the pixel sequencer. It can be the first byte of a two-byte register write. It can be a register read, which sends the selected register back on a framed serial output after a fixed delay. The block holds the control registers for three pixel zones, each with one signed-magnitude offset and one gain. It also holds one mode register, whose bit 4 puts the analog section to sleep.

The decoder state machine has two states. `DEC_IDLE` classifies each byte. A write-class byte moves the machine to `DEC_WDATA`, which takes the next byte as data, writes it and returns to `DEC_IDLE`. A break pulse from the receiver forces `DEC_IDLE` from either state.

The read-back state machine has five states. A read request moves it from `RB_IDLE` to `RB_WAIT`. When the delay count expires it goes to `RB_START`, which sends the low start bit. It then enters `RB_DATA` for eight bits, sent LSB first. After the last data bit it goes to `RB_STOP`, which sends the high stop bit, and from there back to `RB_IDLE`. A cancel from any state returns it to `RB_IDLE`. The serial output is retimed on the falling clock edge.

Top module: `zone_cmd_decoder`

## Requirements
- R1: The bytes 0x1B (main reset), 0x08 (start integration), 0x10 (sample), 0x02 (read pixels) and 0x19 (abort read) each raise only their own strobe. The byte 0x12 raises sample and read pixels together. The byte 0x16 raises sample, read pixels and start integration together. Each strobe is high for exactly the one cycle that follows the clock edge that accepted the byte.
- R2: Any other byte whose bits 7:5 are neither 010 nor 011 raises no strobe and leaves the serial output high.
- R3: A byte with bits 7:5 = 010 carries a register address in bits 4:0. The next accepted byte is stored at that address and is visible on the register ports in the cycle after it is accepted. Neither byte raises a strobe.
- R4: Zone z (0 = left, 1 = center, 2 = right) has its offset at address 2z and its gain at address 2z+1. The mode register is at address 0x1F. Offsets and mode keep 8 bits, a gain keeps the low 5 bits of its data byte, and `sleep` equals bit 4 of the mode register.
- R5: A write to any other address changes no register.
- R6: A byte with bits 7:5 = 011 reads the register addressed in bits 4:0. The output holds high until the 4th rising edge after the accepting edge, and the start bit (0) appears on `sdout` at the falling edge that follows that rising edge. Eight data bits follow, LSB first, then a stop bit (1), one bit per clock. `sdout` changes only on falling edges and rests high.
- R7: A read of an unmapped address returns 0x00, and a gain read returns the 5-bit value zero-extended to 8 bits.
- R8: While a data byte is pending, a 0x1B is stored as data and raises no strobe. The next 0x1B then acts as main reset, so three successive 0x1B bytes always leave the decoder synchronised.
- R9: A pulse on `rx_break` discards a pending write, and the byte after it is decoded as a command.
- R10: A main-reset byte or a break pulse cancels a read-back in progress, and `sdout` returns to and stays high.
- R11: While `rst_n` is low, all strobes are low, `sdout` is high and the mode register is 0x00. Gain and offset registers are not initialised by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break detected by the receiver (one-cycle pulse) |
| act_reset | output | 1 | Main-reset strobe |
| act_start_int | output | 1 | Start-integration strobe |
| act_sample | output | 1 | Sample strobe |
| act_read | output | 1 | Read-pixels strobe |
| act_abort | output | 1 | Abort-read strobe |
| zone_offset | output | N_ZONES*OFS_W | Offset registers, zone z at bits z*OFS_W upward |
| zone_gain | output | N_ZONES*GAIN_W | Gain registers, zone z at bits z*GAIN_W upward |
| mode_reg | output | 8 | Mode register |
| sleep | output | 1 | Sleep request, mode register bit 4 |
| sdout | output | 1 | Framed register read-back, changes on falling edges |

## Verification
The assertions assume that the receiver presents at most one byte per cycle and that `rx_break` is a pulse. When a break and a byte arrive in the same cycle, the break wins and the byte is dropped. The bench keeps inside these assumptions: it presents each byte for one cycle, separated by an idle cycle, and never overlaps a break with a byte. Because gain and offset contents are undefined after reset, the bench reads no gain or offset register until it has written it. It also issues no read-class byte during the action sweep.

// File: rtl/zcd_pkg.sv
`timescale 1ns/1ps
package zcd_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_ADDR_W = 5;
    localparam int SLEEP_BIT  = 4;

    localparam logic [BYTE_W-1:0] OP_MAIN_RESET = 8'h1B;
    localparam logic [BYTE_W-1:0] OP_START      = 8'h08;
    localparam logic [BYTE_W-1:0] OP_SAMPLE     = 8'h10;
    localparam logic [BYTE_W-1:0] OP_READPIX    = 8'h02;
    localparam logic [BYTE_W-1:0] OP_ABORT      = 8'h19;
    localparam logic [BYTE_W-1:0] OP_HOLD       = 8'h12;
    localparam logic [BYTE_W-1:0] OP_HOLD_START = 8'h16;

    localparam logic [2:0] CLS_WRITE = 3'b010;
    localparam logic [2:0] CLS_READ  = 3'b011;

    typedef enum logic {
        DEC_IDLE,
        DEC_WDATA
    } dec_state_e;

    typedef enum logic [2:0] {
        RB_IDLE,
        RB_WAIT,
        RB_START,
        RB_DATA,
        RB_STOP
    } rb_state_e;

    typedef struct packed {
        logic rst;
        logic start;
        logic sample;
        logic readpix;
        logic abort;
    } act_t;

    function automatic act_t decode_action(input logic [BYTE_W-1:0] b);
        act_t a;
        a = '0;
        case (b)
            OP_MAIN_RESET: a.rst     = 1'b1;
            OP_START:      a.start   = 1'b1;
            OP_SAMPLE:     a.sample  = 1'b1;
            OP_READPIX:    a.readpix = 1'b1;
            OP_ABORT:      a.abort   = 1'b1;
            OP_HOLD: begin
                a.sample  = 1'b1;
                a.readpix = 1'b1;
            end
            OP_HOLD_START: begin
                a.sample  = 1'b1;
                a.readpix = 1'b1;
                a.start   = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/zcd_decode.sv
`timescale 1ns/1ps
module zcd_decode
    import zcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic                  rx_break,
    output act_t                  act_q,
    output logic                  wr_en,
    output logic [REG_ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  rd_req,
    output logic [REG_ADDR_W-1:0] rd_addr,
    output logic                  rb_cancel,
    output logic                  pend
);

    dec_state_e            state, nxt;
    logic [REG_ADDR_W-1:0] addr_q, addr_d;
    act_t                  act_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= DEC_IDLE;
            addr_q <= '0;
        end else begin
            state  <= nxt;
            addr_q <= addr_d;
        end
    end

    // next state and command classification
    always_comb begin
        nxt    = state;
        addr_d = addr_q;
        act_d  = '0;
        wr_en  = 1'b0;
        rd_req = 1'b0;
        if (rx_break) begin
            nxt = DEC_IDLE;
        end else if (rx_valid) begin
            unique case (state)
                DEC_IDLE: begin
                    if (rx_byte[7:5] == CLS_WRITE) begin
                        nxt    = DEC_WDATA;
                        addr_d = rx_byte[REG_ADDR_W-1:0];
                    end else if (rx_byte[7:5] == CLS_READ) begin
                        rd_req = 1'b1;
                    end else begin
                        act_d = decode_action(rx_byte);
                    end
                end
                DEC_WDATA: begin
                    wr_en = 1'b1;
                    nxt   = DEC_IDLE;
                end
            endcase
        end
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign wr_addr   = addr_q;
    assign wr_data   = rx_byte;
    assign rd_addr   = rx_byte[REG_ADDR_W-1:0];
    assign rb_cancel = rx_break | act_d.rst;
    assign pend      = (state == DEC_WDATA);

endmodule

// File: rtl/zcd_regfile.sv
`timescale 1ns/1ps
module zcd_regfile
    import zcd_pkg::*;
#(
    parameter int                    N_ZONES   = 3,
    parameter int                    OFS_W     = 8,
    parameter int                    GAIN_W    = 5,
    parameter logic [REG_ADDR_W-1:0] MODE_ADDR = 5'h1F
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_ADDR_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [REG_ADDR_W-1:0]     rd_addr,
    output logic [BYTE_W-1:0]         rd_data,
    output logic [N_ZONES*OFS_W-1:0]  zone_offset,
    output logic [N_ZONES*GAIN_W-1:0] zone_gain,
    output logic [BYTE_W-1:0]         mode_q
);

    logic [BYTE_W-1:0] zone_rd [N_ZONES];

    for (genvar z = 0; z < N_ZONES; z++) begin : g_zone
        localparam logic [REG_ADDR_W-1:0] A_OFS  = REG_ADDR_W'(2 * z);
        localparam logic [REG_ADDR_W-1:0] A_GAIN = REG_ADDR_W'(2 * z + 1);

        logic [OFS_W-1:0]  ofs_r;
        logic [GAIN_W-1:0] gain_r;

        // gain and offset are left uninitialised by reset
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == A_OFS)  ofs_r  <= wr_data[OFS_W-1:0];
            if (wr_en && wr_addr == A_GAIN) gain_r <= wr_data[GAIN_W-1:0];
        end

        assign zone_offset[z*OFS_W +: OFS_W]  = ofs_r;
        assign zone_gain[z*GAIN_W +: GAIN_W] = gain_r;
        assign zone_rd[z] = (rd_addr == A_OFS)  ? BYTE_W'(ofs_r)  :
                            (rd_addr == A_GAIN) ? BYTE_W'(gain_r) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mode_q <= '0;
        else if (wr_en && wr_addr == MODE_ADDR) mode_q <= wr_data;
    end

    always_comb begin
        rd_data = (rd_addr == MODE_ADDR) ? mode_q : '0;
        for (int z = 0; z < N_ZONES; z++) rd_data = rd_data | zone_rd[z];
    end

endmodule

// File: rtl/zcd_readback.sv
`timescale 1ns/1ps
module zcd_readback
    import zcd_pkg::*;
#(
    parameter int RB_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [BYTE_W-1:0] data,
    input  logic              cancel,
    output logic              sdout,
    output logic              busy
);

    localparam int CNT_MAX = (RB_DELAY > BYTE_W) ? RB_DELAY : BYTE_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rb_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ser_bit;

    // state register with delay and bit counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RB_IDLE;
            cnt   <= '0;
            shreg <= '0;
        end else if (cancel) begin
            state <= RB_IDLE;
            cnt   <= '0;
        end else if (req) begin
            state <= RB_WAIT;
            cnt   <= CNT_W'(RB_DELAY - 1);
            shreg <= data;
        end else begin
            unique case (state)
                RB_IDLE: ;
                RB_WAIT: begin
                    if (cnt == '0) state <= RB_START;
                    else           cnt   <= cnt - 1'b1;
                end
                RB_START: begin
                    state <= RB_DATA;
                    cnt   <= CNT_W'(BYTE_W - 1);
                end
                RB_DATA: begin
                    shreg <= shreg >> 1;
                    if (cnt == '0) state <= RB_STOP;
                    else           cnt   <= cnt - 1'b1;
                end
                RB_STOP: state <= RB_IDLE;
                default: state <= RB_IDLE;
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            RB_START: ser_bit = 1'b0;
            RB_DATA:  ser_bit = shreg[0];
            default:  ser_bit = 1'b1;
        endcase
    end

    // falling-edge retiming of the line
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sdout <= 1'b1;
        else        sdout <= ser_bit;
    end

    assign busy = (state != RB_IDLE);

endmodule

// File: rtl/zone_cmd_decoder.sv
`timescale 1ns/1ps
module zone_cmd_decoder
    import zcd_pkg::*;
#(
    parameter int                    N_ZONES   = 3,
    parameter int                    OFS_W     = 8,
    parameter int                    GAIN_W    = 5,
    parameter int                    RB_DELAY  = 4,
    parameter logic [REG_ADDR_W-1:0] MODE_ADDR = 5'h1F
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_byte,
    input  logic                      rx_break,
    output logic                      act_reset,
    output logic                      act_start_int,
    output logic                      act_sample,
    output logic                      act_read,
    output logic                      act_abort,
    output logic [N_ZONES*OFS_W-1:0]  zone_offset,
    output logic [N_ZONES*GAIN_W-1:0] zone_gain,
    output logic [7:0]                mode_reg,
    output logic                      sleep,
    output logic                      sdout
);

    act_t                  act_q;
    logic                  wr_en, rd_req, rb_cancel, wr_pending, rb_busy;
    logic [REG_ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0]     wr_data, rd_data;

    zcd_decode i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_break  (rx_break),
        .act_q     (act_q),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rb_cancel (rb_cancel),
        .pend      (wr_pending)
    );

    zcd_regfile #(
        .N_ZONES   (N_ZONES),
        .OFS_W     (OFS_W),
        .GAIN_W    (GAIN_W),
        .MODE_ADDR (MODE_ADDR)
    ) i_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .zone_offset (zone_offset),
        .zone_gain   (zone_gain),
        .mode_q      (mode_reg)
    );

    zcd_readback #(
        .RB_DELAY (RB_DELAY)
    ) i_readback (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (rd_req),
        .data   (rd_data),
        .cancel (rb_cancel),
        .sdout  (sdout),
        .busy   (rb_busy)
    );

    assign act_reset     = act_q.rst;
    assign act_start_int = act_q.start;
    assign act_sample    = act_q.sample;
    assign act_read      = act_q.readpix;
    assign act_abort     = act_q.abort;
    assign sleep         = mode_reg[SLEEP_BIT];

endmodule

// File: rtl/zcd_checker.sv
`timescale 1ns/1ps
module zcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rx_break,
    input logic       act_reset,
    input logic       act_start_int,
    input logic       act_sample,
    input logic       act_read,
    input logic       act_abort,
    input logic       sdout,
    input logic       pend,
    input logic       rb_busy
);

    // R1: a read-pixels strobe only follows a byte accepted as a command
    p_strobe_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_read |-> ($past(rx_valid) && !$past(rx_break) && !$past(pend)));

    // R1: main reset never combines with another action
    p_reset_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_reset |-> !(act_start_int || act_sample || act_read || act_abort));

    // R3: the data byte of a write completes it and raises no strobe
    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && rx_valid && !rx_break) |=>
        (!pend && !(act_reset || act_start_int || act_sample || act_read || act_abort)));

    // R6: a read-class byte in the idle state starts the read-back engine
    p_read_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && rx_valid && !rx_break && rx_byte[7:5] == 3'b011) |=> rb_busy);

    // R6: the line rests high whenever the read-back engine is idle
    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_busy |-> sdout);

    // R9: a break drops any pending write
    p_break_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> !pend);

    // R10: main reset or break cancels read-back
    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break || (!pend && rx_valid && rx_byte == 8'h1B)) |=> !rb_busy);

endmodule

bind zone_cmd_decoder zcd_checker i_zcd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_byte       (rx_byte),
    .rx_break      (rx_break),
    .act_reset     (act_reset),
    .act_start_int (act_start_int),
    .act_sample    (act_sample),
    .act_read      (act_read),
    .act_abort     (act_abort),
    .sdout         (sdout),
    .pend          (wr_pending),
    .rb_busy       (rb_busy)
);

// File: tb/test_zone_cmd_decoder.sv
`timescale 1ns/1ps
module test_zone_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NZ = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_break = 1'b0;
    logic        act_reset, act_start_int, act_sample, act_read, act_abort;
    logic [NZ*8-1:0] zone_offset;
    logic [NZ*5-1:0] zone_gain;
    logic [7:0]  mode_reg;
    logic        sleep, sdout;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    zone_cmd_decoder i_zone_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .act_reset(act_reset), .act_start_int(act_start_int),
        .act_sample(act_sample), .act_read(act_read), .act_abort(act_abort),
        .zone_offset(zone_offset), .zone_gain(zone_gain), .mode_reg(mode_reg),
        .sleep(sleep), .sdout(sdout)
    );

    function automatic logic [4:0] acts();
        return {act_reset, act_start_int, act_sample, act_read, act_abort};
    endfunction

    // {reset, start, sample, read, abort}
    function automatic logic [4:0] exp_act(input logic [7:0] b);
        case (b)
            8'h1B: return 5'b10000;
            8'h08: return 5'b01000;
            8'h10: return 5'b00100;
            8'h02: return 5'b00010;
            8'h19: return 5'b00001;
            8'h12: return 5'b00110;
            8'h16: return 5'b01110;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic bit mapped(input int a);
        return (a < 2*NZ) || (a == 31);
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        if (!mapped(a)) return 8'h00;
        if (a < 2*NZ && a % 2 == 1) return mdl[a] & 8'h1F;
        return mdl[a];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // byte accepted at the rising edge inside; returns 1 time unit after the next falling edge
    task automatic send(input logic [7:0] b);
        @(negedge clk); #1;
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic pulse_break();
        @(negedge clk); #1;
        rx_break = 1'b1;
        @(negedge clk); #1;
        rx_break = 1'b0;
    endtask

    task automatic write_reg(input int a, input logic [7:0] d);
        send(8'h40 | 8'(a));
        send(d);
        if (mapped(a)) mdl[a] = d;
    endtask

    task automatic check_ports(input string req);
        for (int z = 0; z < NZ; z++) begin
            check(zone_offset[z*8 +: 8] === mdl[2*z], req, zone_offset[z*8 +: 8], mdl[2*z]);
            check(zone_gain[z*5 +: 5] === mdl[2*z+1][4:0], req, zone_gain[z*5 +: 5], mdl[2*z+1][4:0]);
        end
        check(mode_reg === mdl[31], req, mode_reg, mdl[31]);
    endtask

    // called right after send() of a read byte
    task automatic expect_frame(input logic [7:0] e, input string req);
        logic       early_hi;
        logic [9:0] frame;
        early_hi = (sdout === 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            if (sdout !== 1'b1) early_hi = 1'b0;
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            frame[i] = sdout;
        end
        check(early_hi && frame === {1'b1, e, 1'b0}, req, {early_hi, frame}, {1'b1, 1'b1, e, 1'b0});
    endtask

    task automatic expect_quiet_line(input int cycles, input string req);
        logic hi;
        hi = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #1;
            if (sdout !== 1'b1) hi = 1'b0;
        end
        check(hi, req, hi, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;

        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        check(acts() === 5'b0 && sdout === 1'b1, "R11 reset outputs", {acts(), sdout}, 6'b000001);
        check(mode_reg === 8'h00 && sleep === 1'b0, "R11 mode reset", mode_reg, 0);
        rst_n = 1'b1;

        // R1 / R2: sweep every byte that is neither write- nor read-class
        for (int b = 0; b < 256; b++) begin
            if (b[7:5] != 3'b010 && b[7:5] != 3'b011) begin
                send(8'(b));
                check(acts() === exp_act(8'(b)), (exp_act(8'(b)) != 0) ? "R1 action strobe" : "R2 no strobe",
                      acts(), exp_act(8'(b)));
                @(negedge clk); #1;
                check(acts() === 5'b0 && sdout === 1'b1, "R1 single-cycle strobe, R2 line high",
                      {acts(), sdout}, 6'b000001);
            end
        end

        // R3 / R4: write every mapped register, gain bytes carry upper junk
        for (int z = 0; z < NZ; z++) begin
            write_reg(2*z, 8'h80 | 8'(z*37 + 5));
            check(acts() === 5'b0, "R3 write raises no strobe", acts(), 0);
            write_reg(2*z + 1, 8'hE0 | 8'(z*9 + 3));
        end
        write_reg(31, 8'h10);
        check_ports("R3 R4 register ports");
        check(sleep === 1'b1, "R4 sleep bit", sleep, 1);

        // R5: unmapped writes leave every register alone
        for (int a = 2*NZ; a < 31; a++) write_reg(a, 8'h5A ^ 8'(a));
        check_ports("R5 unmapped write ignored");

        // R6 / R7: read back the whole address space
        for (int a = 0; a < 32; a++) begin
            send(8'h60 | 8'(a));
            expect_frame(exp_rd(a), mapped(a) ? "R6 framed read-back" : "R7 unmapped reads zero");
        end
        write_reg(3, 8'hFF);
        send(8'h63);
        expect_frame(8'h1F, "R7 gain zero-extended");

        // R8: a pending write swallows the first 0x1B as data
        send(8'h42);
        send(8'h1B);
        mdl[2] = 8'h1B;
        check(acts() === 5'b0, "R8 0x1B as data no strobe", acts(), 0);
        check(zone_offset[15:8] === 8'h1B, "R8 0x1B stored", zone_offset[15:8], 8'h1B);
        send(8'h1B);
        check(acts() === 5'b10000, "R8 next 0x1B resets", acts(), 5'b10000);

        // R9: break drops a pending write
        send(8'h44);
        pulse_break();
        send(8'h08);
        check(acts() === 5'b01000, "R9 byte after break decoded", acts(), 5'b01000);
        check_ports("R9 pending write discarded");

        // R10: main reset cancels read-back
        send(8'h60);
        @(negedge clk); #1;
        send(8'h1B);
        expect_quiet_line(16, "R10 reset cancels read-back");
        // R10: break cancels read-back
        send(8'h7F);
        pulse_break();
        expect_quiet_line(16, "R10 break cancels read-back");

        // R4: leaving sleep
        write_reg(31, 8'h00);
        check(sleep === 1'b0 && mode_reg === 8'h00, "R4 sleep cleared", {sleep, mode_reg}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule